// File: doc/BRIEF.md
# Eight-Port Self-Routing Banyan Fabric

This block joins eight input streams to eight output streams through three ranks of two-by-two switching nodes. There is no central scheduler. Every packet carries a three-bit destination port number, and each rank reads one bit of it to choose between its node's two outputs. The top bit is read first and the bottom bit last. The nodes are wired in a butterfly, so any input reaches the output whose index equals the destination.

Each node holds one registered slot per output. A packet that meets no contention therefore comes out a fixed number of cycles after it is accepted. When both inputs of a node want the same output in the same cycle, a toggling priority grants one of them. The other sees its ready low and keeps its packet until a later grant, so nothing is dropped. Output streams have no backpressure; a valid output word is taken in the cycle it is shown.

Top module: `selfroute_fabric`

## Requirements
- R1: A packet offered on any input with destination d appears on output d with its payload unchanged. Routing needs no inputs beyond the packet's own fields. The full identity mapping (input i to output i) and the full complement mapping (input i to output 7-i) each pass in one cycle with all eight inputs accepted together.
- R2: Whenever `out_valid[o]` is high, the destination field shown on output o equals o.
- R3: Each rank node uses one destination bit: rank 0 uses bit 2, rank 1 uses bit 1 and rank 2 uses bit 0. A bit value of 1 selects the node's lower output and 0 its upper output.
- R4: A packet that meets no contention is accepted in the cycle it is offered (ready high). It appears on its output after the third rising edge that follows. The rising edge that accepts it is counted as the first.
- R5: When two inputs of one node request the same node output in a cycle, exactly one of them sees ready high. This holds whether the two packets share a destination or only a path. The other input keeps its packet and is delivered later. When nothing else interferes, it leaves one cycle after the winner.
- R6: The grant between the two inputs of a node alternates. After a contention is resolved in favour of one input, the next contention at the same node output goes to the other input. After reset the upper input (the lower-numbered line) is favoured.
- R7: An input with valid low never gets ready high and never produces an output, whatever its destination and payload fields hold. After reset every output shows valid low.
- R8: No packet is lost or duplicated. Packets from one input to one output leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | PORTS | Per-input packet present |
| in_dest | input | PORTS*DEST_W | Per-input destination port number, input i at bits [i*DEST_W +: DEST_W] |
| in_data | input | PORTS*DATA_W | Per-input payload, input i at bits [i*DATA_W +: DATA_W] |
| in_ready | output | PORTS | Per-input acceptance; a packet moves when valid and ready are both high at a rising edge |
| out_valid | output | PORTS | Per-output packet present, registered |
| out_dest | output | PORTS*DEST_W | Per-output destination field, registered |
| out_data | output | PORTS*DATA_W | Per-output payload, registered |

## Verification
Single isolated packets on chosen routes, including 101 from input 0, check the per-rank bit steering and the three-cycle latency. The identity and complement mappings drive all eight inputs at once. They show that conflict-free traffic is never blocked, and a mis-wired butterfly would break them. Directed pairs of inputs that collide at the first rank, once with one shared destination and once with different destinations, separate a correct single grant and an alternating priority from a fixed priority or a dropped loser. Long random runs follow: first uniform destinations, then a hot-spot mix aimed only at outputs 0 and 7. Each payload carries its source and a per-pair sequence number, which catches loss, duplication, reordering and misrouting under heavy internal blocking.

// File: rtl/sr_fabric_pkg.sv
package sr_fabric_pkg;

  // Priority state of one node output: which input wins a tie.
  typedef enum logic {
    FAVOR_UPPER = 1'b0,
    FAVOR_LOWER = 1'b1
  } rr_pref_t;

  // Lower line of pair number e when lines are paired on bit p:
  // a zero is inserted at bit position p of e.
  function automatic int pair_low_line(input int e, input int p);
    return ((e >> p) << (p + 1)) | (e & ((1 << p) - 1));
  endfunction

endpackage

// File: rtl/sr_rr_arb.sv
module sr_rr_arb
  import sr_fabric_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic       advance,
  output logic [1:0] gnt
);

  rr_pref_t pref;

  always_comb begin
    if (req == 2'b11) begin
      gnt = (pref == FAVOR_LOWER) ? 2'b10 : 2'b01;
    end else begin
      gnt = req;
    end
  end

  // Flip the preference only when a tie was actually resolved.
  always_ff @(posedge clk) begin
    if (rst) begin
      pref <= FAVOR_UPPER;
    end else if (req == 2'b11 && advance) begin
      pref <= gnt[0] ? FAVOR_LOWER : FAVOR_UPPER;
    end
  end

endmodule

// File: rtl/sr_node.sv
module sr_node #(
  parameter int DEST_W  = 3,
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          in_v,
  input  logic [2*DEST_W-1:0] in_dest,
  input  logic [2*DATA_W-1:0] in_data,
  output logic [1:0]          in_rdy,
  output logic [1:0]          out_v,
  output logic [2*DEST_W-1:0] out_dest,
  output logic [2*DATA_W-1:0] out_data,
  input  logic [1:0]          out_rdy
);

  logic [1:0] steer;
  logic [1:0] load_ok;
  logic [1:0] gnt [2];

  assign steer[0] = in_dest[SEL_BIT];
  assign steer[1] = in_dest[DEST_W + SEL_BIT];

  for (genvar o = 0; o < 2; o++) begin : g_out
    logic [1:0] req;
    assign req[0]     = in_v[0] && (steer[0] == 1'(o));
    assign req[1]     = in_v[1] && (steer[1] == 1'(o));
    assign load_ok[o] = !out_v[o] || out_rdy[o];

    sr_rr_arb u_arb (
      .clk     (clk),
      .rst     (rst),
      .req     (req),
      .advance (load_ok[o]),
      .gnt     (gnt[o])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        out_v[o] <= 1'b0;
      end else if (load_ok[o]) begin
        out_v[o] <= |gnt[o];
      end
    end

    always_ff @(posedge clk) begin
      if (load_ok[o] && (|gnt[o])) begin
        out_dest[o*DEST_W +: DEST_W] <= gnt[o][1] ? in_dest[DEST_W +: DEST_W]
                                                  : in_dest[0 +: DEST_W];
        out_data[o*DATA_W +: DATA_W] <= gnt[o][1] ? in_data[DATA_W +: DATA_W]
                                                  : in_data[0 +: DATA_W];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      in_rdy[i] = (gnt[0][i] && load_ok[0]) || (gnt[1][i] && load_ok[1]);
    end
  end

endmodule

// File: rtl/selfroute_fabric.sv
module selfroute_fabric
  import sr_fabric_pkg::*;
#(
  parameter int PORTS  = 8,
  parameter int DATA_W = 16,
  parameter int DEST_W = $clog2(PORTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PORTS-1:0]         in_valid,
  input  logic [PORTS*DEST_W-1:0]  in_dest,
  input  logic [PORTS*DATA_W-1:0]  in_data,
  output logic [PORTS-1:0]         in_ready,
  output logic [PORTS-1:0]         out_valid,
  output logic [PORTS*DEST_W-1:0]  out_dest,
  output logic [PORTS*DATA_W-1:0]  out_data
);

  localparam int STAGES = DEST_W;
  localparam int HALF   = PORTS / 2;
  localparam int LINES  = (STAGES + 1) * PORTS;

  // Line bundles between ranks: rank s reads lines [s*PORTS +: PORTS].
  logic [LINES-1:0]        lv;
  logic [LINES-1:0]        lr;
  logic [LINES*DEST_W-1:0] ld;
  logic [LINES*DATA_W-1:0] lp;

  assign lv[0 +: PORTS]          = in_valid;
  assign ld[0 +: PORTS*DEST_W]   = in_dest;
  assign lp[0 +: PORTS*DATA_W]   = in_data;
  assign in_ready                = lr[0 +: PORTS];
  assign out_valid               = lv[STAGES*PORTS +: PORTS];
  assign out_dest                = ld[STAGES*PORTS*DEST_W +: PORTS*DEST_W];
  assign out_data                = lp[STAGES*PORTS*DATA_W +: PORTS*DATA_W];
  assign lr[STAGES*PORTS +: PORTS] = '1;

  for (genvar s = 0; s < STAGES; s++) begin : g_rank
    for (genvar e = 0; e < HALF; e++) begin : g_node
      localparam int SEL = STAGES - 1 - s;
      localparam int LO  = pair_low_line(e, SEL);
      localparam int HI  = LO + (1 << SEL);
      localparam int A   = s * PORTS;
      localparam int B   = (s + 1) * PORTS;

      logic [1:0]          n_rdy;
      logic [1:0]          n_v;
      logic [2*DEST_W-1:0] n_d;
      logic [2*DATA_W-1:0] n_p;

      sr_node #(
        .DEST_W  (DEST_W),
        .DATA_W  (DATA_W),
        .SEL_BIT (SEL)
      ) u_node (
        .clk      (clk),
        .rst      (rst),
        .in_v     ({lv[A+HI], lv[A+LO]}),
        .in_dest  ({ld[(A+HI)*DEST_W +: DEST_W], ld[(A+LO)*DEST_W +: DEST_W]}),
        .in_data  ({lp[(A+HI)*DATA_W +: DATA_W], lp[(A+LO)*DATA_W +: DATA_W]}),
        .in_rdy   (n_rdy),
        .out_v    (n_v),
        .out_dest (n_d),
        .out_data (n_p),
        .out_rdy  ({lr[B+HI], lr[B+LO]})
      );

      assign lr[A+LO] = n_rdy[0];
      assign lr[A+HI] = n_rdy[1];
      assign lv[B+LO] = n_v[0];
      assign lv[B+HI] = n_v[1];
      assign ld[(B+LO)*DEST_W +: DEST_W] = n_d[0 +: DEST_W];
      assign ld[(B+HI)*DEST_W +: DEST_W] = n_d[DEST_W +: DEST_W];
      assign lp[(B+LO)*DATA_W +: DATA_W] = n_p[0 +: DATA_W];
      assign lp[(B+HI)*DATA_W +: DATA_W] = n_p[DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/selfroute_fabric_chk.sv
module selfroute_fabric_chk #(
  parameter int PORTS  = 8,
  parameter int DEST_W = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PORTS-1:0]        in_valid,
  input logic [PORTS*DEST_W-1:0] in_dest,
  input logic [PORTS-1:0]        in_ready,
  input logic [PORTS-1:0]        out_valid,
  input logic [PORTS*DEST_W-1:0] out_dest
);

  localparam int HALF = PORTS / 2;

  logic [15:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= '0;
    end else begin
      inflight <= inflight + 16'($countones(in_valid & in_ready))
                           - 16'($countones(out_valid));
    end
  end

  // R7: outputs idle on the first cycle after reset.
  p_idle_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_valid == '0));

  // R8: never more packets visible at the outputs than accepted and not yet delivered.
  p_no_phantom_r8: assert property (@(posedge clk) disable iff (rst)
    16'($countones(out_valid)) <= inflight);

  for (genvar o = 0; o < PORTS; o++) begin : g_o
    // R2: output o only ever carries destination o.
    p_dest_match_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] |-> (out_dest[o*DEST_W +: DEST_W] == DEST_W'(o)));
  end

  for (genvar i = 0; i < PORTS; i++) begin : g_i
    // R7: an input without valid is never accepted.
    p_ready_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
      in_ready[i] |-> in_valid[i]);
  end

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    // R5: a first-rank pair asking for the same side gets at most one grant.
    p_one_grant_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid[i] && in_valid[i+HALF] &&
       (in_dest[i*DEST_W + DEST_W-1] == in_dest[(i+HALF)*DEST_W + DEST_W-1]))
      |-> !(in_ready[i] && in_ready[i+HALF]));
  end

endmodule

bind selfroute_fabric selfroute_fabric_chk #(
  .PORTS  (PORTS),
  .DEST_W (DEST_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_dest   (in_dest),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_dest  (out_dest)
);

// File: tb/test_selfroute_fabric.sv
`timescale 1ns/1ps
module test_selfroute_fabric;

  localparam int N  = 8;
  localparam int DW = 3;
  localparam int PW = 16;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    in_valid;
  logic [N*DW-1:0] in_dest;
  logic [N*PW-1:0] in_data;
  logic [N-1:0]    in_ready;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_dest;
  logic [N*PW-1:0] out_data;

  always #10 clk = ~clk;

  selfroute_fabric #(.PORTS(N), .DATA_W(PW)) i_selfroute_fabric (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_dest(out_dest), .out_data(out_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cyc    = 0;
  int rand_pct = 0;
  bit hot    = 1'b0;

  bit [N-1:0]    hold_v = '0;
  bit [N-1:0]    acc    = '0;
  int            hold_d [N];
  logic [PW-1:0] hold_p [N];
  int            sent [N][N];
  int            rcvd [N][N];
  int            last_arr [N];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic end_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic int pick_dest();
    if (hot) return ($urandom % 2 == 0) ? 0 : 7;
    return int'($urandom % N);
  endfunction

  // Payload: bits [15:13] source, bits [12:0] per (source,destination) sequence.
  task automatic offer(input int s, input int d);
    if (!hold_v[s]) begin
      hold_v[s] = 1'b1;
      hold_d[s] = d;
      hold_p[s] = {3'(s), 13'(sent[s][d])};
      sent[s][d]++;
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      in_valid[i] = hold_v[i];
      in_dest[i*DW +: DW] = hold_v[i] ? DW'(hold_d[i]) : DW'($urandom);
      in_data[i*PW +: PW] = hold_v[i] ? hold_p[i] : PW'($urandom);
    end
    #1;
    for (int i = 0; i < N; i++) acc[i] = hold_v[i] && in_ready[i];
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    for (int o = 0; o < N; o++) begin
      if (out_valid[o]) begin
        int d, s, c;
        d = int'(out_dest[o*DW +: DW]);
        s = int'(out_data[o*PW + 13 +: 3]);
        c = int'(out_data[o*PW +: 13]);
        chk(d == o, "R2 dest field on output", d, o);
        chk(c == (rcvd[s][o] % 8192), "R1/R8 payload order per source", c, rcvd[s][o] % 8192);
        rcvd[s][o]++;
        last_arr[s] = cyc;
      end
    end
    for (int i = 0; i < N; i++) if (acc[i]) hold_v[i] = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (rand_pct > 0 && !hold_v[i] && int'($urandom % 100) < rand_pct) offer(i, pick_dest());
    end
    drive();
  endtask

  task automatic drain(input int n);
    rand_pct = 0;
    repeat (n) tick();
  endtask

  // R3/R4: single packet, isolated; exits after the third edge.
  task automatic lat_test(input int s, input int d);
    drain(8);
    offer(s, d);
    drive();
    chk(acc[s], "R4 uncontended accept", int'(acc[s]), 1);
    tick();
    chk(out_valid == '0, "R4 latency edge 1", int'(out_valid), 0);
    tick();
    chk(out_valid == '0, "R4 latency edge 2", int'(out_valid), 0);
    tick();
    chk(out_valid == N'(1 << d), "R3 route by bits", int'(out_valid), 1 << d);
  endtask

  // R1: conflict-free full mapping.
  task automatic perm_test(input bit complement);
    drain(8);
    for (int i = 0; i < N; i++) offer(i, complement ? (N - 1 - i) : i);
    drive();
    chk(acc == '1, "R1 full mapping accepted", int'(acc), 255);
    repeat (3) tick();
    chk(out_valid == '1, "R1 full mapping delivered", int'(out_valid), 255);
  endtask

  // R5: inputs 0 and 4 meet at the same first-rank node.
  task automatic contend(input int d0, input int d4, output int winner);
    int loser;
    drain(8);
    offer(0, d0);
    offer(4, d4);
    drive();
    chk((acc[0] ^ acc[4]) == 1'b1, "R5 exactly one grant", int'({acc[4], acc[0]}), 1);
    winner = acc[0] ? 0 : 4;
    loser  = acc[0] ? 4 : 0;
    repeat (6) tick();
    chk(rcvd[0][d0] == sent[0][d0], "R5 input 0 delivered", rcvd[0][d0], sent[0][d0]);
    chk(rcvd[4][d4] == sent[4][d4], "R5 input 4 delivered", rcvd[4][d4], sent[4][d4]);
    chk(last_arr[loser] == last_arr[winner] + 1, "R5 loser one cycle later",
        last_arr[loser] - last_arr[winner], 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end_run();
  end

  initial begin
    int w1, w2, w3;
    void'($urandom(32'h5EED_0042));
    for (int s = 0; s < N; s++) begin
      last_arr[s] = 0;
      for (int d = 0; d < N; d++) begin
        sent[s][d] = 0;
        rcvd[s][d] = 0;
      end
    end
    rst = 1'b1;
    drive();
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R7 reset outputs idle", int'(out_valid), 0);
    rst = 1'b0;
    drive();

    // R7: idle inputs with junk fields.
    repeat (5) begin
      tick();
      chk(out_valid == '0, "R7 no output without valid", int'(out_valid), 0);
      chk(in_ready == '0, "R7 no ready without valid", int'(in_ready), 0);
    end

    lat_test(0, 5);
    lat_test(7, 0);
    lat_test(3, 6);
    lat_test(6, 1);

    perm_test(1'b0);
    perm_test(1'b1);

    contend(3, 3, w1);
    chk(w1 == 0, "R6 first tie to upper input", w1, 0);
    contend(3, 3, w2);
    chk(w2 != w1, "R6 priority alternates", w2, 4 - w1);
    contend(0, 1, w3);
    chk(w3 != w2, "R6 alternates on shared path", w3, 4 - w2);

    rand_pct = 60;
    hot = 1'b0;
    repeat (3000) tick();
    rand_pct = 70;
    hot = 1'b1;
    repeat (1500) tick();
    hot = 1'b0;
    drain(30);
    for (int s = 0; s < N; s++) begin
      int ts, tr;
      ts = 0;
      tr = 0;
      for (int d = 0; d < N; d++) begin
        ts += sent[s][d];
        tr += rcvd[s][d];
      end
      chk(ts == tr, "R8 no loss or duplication", tr, ts);
    end
    end_run();
  end

endmodule